// File: doc/BRIEF.md
# Sensorless Six-Step Commutation Sequencer

This block commutates a three-phase brushless motor that has no position sensors. A single digital comparator bit reports the sign of the back-EMF on whichever phase is currently left floating. That sign is measured against the motor star point. The block keeps a six-step drive pattern and moves it on by one step for each accepted zero crossing of that signal. It also reports which phase the comparator should be watching.

Every accepted crossing latches the time since the previous one, counted in prescaled ticks. The block then ignores the comparator for a blanking interval of one quarter of that period. This prevents the ringing that follows a commutation from being read as a crossing. If the period count saturates, the motor is treated as stalled and the power stage is switched off. Dropping the enable returns the sequence to its first step and loads a startup period chosen by the integrator.

Top module: `bemf_commutator`

## Requirements
- R1: The step index selects the drive. The encodings are: bit 0 = phase A, bit 1 = phase B, bit 2 = phase C for both `hs_en_o` and `ls_en_o`; and `sense_sel_o` 0/1/2 = A/B/C. The six steps give (high, low, floating): 0 (A, B, C), 1 (A, C, B), 2 (B, C, A), 3 (B, A, C), 4 (C, A, B), 5 (C, B, A). `sense_sel_o` names the floating phase.
- R2: Even steps expect the filtered comparator level 1 and odd steps expect 0. An accepted crossing advances the step by exactly one, and step 5 wraps to step 0. Without an accepted crossing the step does not change.
- R3: At most one high-side enable and at most one low-side enable are asserted in any cycle. No phase ever has both its high-side and low-side enable asserted together.
- R4: The comparator passes through a two-flop synchronizer. The filtered level changes only after the synchronized value has differed from it for `FILT_LEN` consecutive clocks. Shorter pulses have no effect on the step.
- R5: After each accepted crossing, the comparator is ignored for `M` ticks, where `M` is the measured period shifted right by two. A tick is `CLK_PER_TICK` clocks, and the prescaler restarts on acceptance.
- R6: Once the blanking interval expires, a filtered level that equals the expected polarity is accepted. This holds even if that level was reached during the blanking interval.
- R7: The period counter increments once per tick and saturates at its all-ones value. While it is saturated, `stall_o` is 1 and all enables are 0. The next accepted crossing clears the counter and therefore clears the stall.
- R8: While `en_i` is 0, all enables are 0 and the step is 0. The timer loads `start_period_i` as the period and `start_period_i >> 2` as the blanking interval. That blanking interval applies from the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low forces idle and reloads the startup period |
| cmp_i | input | 1 | Asynchronous back-EMF comparator bit for the floating phase |
| start_period_i | input | PERIOD_W | Startup period in ticks |
| hs_en_o | output | 3 | High-side enables, bit per phase |
| ls_en_o | output | 3 | Low-side enables, bit per phase |
| sense_sel_o | output | 2 | Floating phase the comparator should observe |
| stall_o | output | 1 | Period counter saturated |

## Verification
The assertions assume that `start_period_i` is held constant while `en_i` is high. They also assume that `cmp_i` may change at any time, because it goes through the synchronizer first. The stimulus changes the comparator only at falling clock edges and keeps a known cycle distance from the last observed step change. Each gap is chosen so that the resulting quarter-period blanking interval lands well away from the sampling instants. Short glitches are kept below the filter length, and real crossings are held far longer than it.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned STEP_W    = 3;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2
  } phase_e;

  typedef struct packed {
    logic [2:0] hs;
    logic [2:0] ls;
    phase_e     sense;
    logic       pol;
  } drive_t;

  function automatic drive_t step_drive(input logic [STEP_W-1:0] step);
    drive_t d;
    d.pol = ~step[0];
    unique case (step)
      3'd0:    begin d.hs = 3'b001; d.ls = 3'b010; d.sense = PH_C; end
      3'd1:    begin d.hs = 3'b001; d.ls = 3'b100; d.sense = PH_B; end
      3'd2:    begin d.hs = 3'b010; d.ls = 3'b100; d.sense = PH_A; end
      3'd3:    begin d.hs = 3'b010; d.ls = 3'b001; d.sense = PH_C; end
      3'd4:    begin d.hs = 3'b100; d.ls = 3'b001; d.sense = PH_B; end
      3'd5:    begin d.hs = 3'b100; d.ls = 3'b010; d.sense = PH_A; end
      default: begin d.hs = 3'b000; d.ls = 3'b000; d.sense = PH_A; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bemf_sync_filter.sv
module bemf_sync_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  output logic level_o
);

  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q, level_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      s1_q <= cmp_i;
      s2_q <= s1_q;
      if (s2_q == level_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        level_q <= s2_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;

  // level only ever moves toward the synchronized value
  assert_filter_follows_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> (level_q == $past(s2_q)));

endmodule

// File: rtl/bemf_period_timer.sv
module bemf_period_timer #(
  parameter int unsigned PERIOD_W     = 16,
  parameter int unsigned CLK_PER_TICK = 125
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                accept_i,
  input  logic [PERIOD_W-1:0] start_period_i,
  output logic                mask_active_o,
  output logic                stall_o
);

  localparam int unsigned        PW      = $clog2(CLK_PER_TICK + 1);
  localparam logic [PERIOD_W-1:0] CNT_MAX = '1;

  logic [PW-1:0]       pre_q;
  logic [PERIOD_W-1:0] cnt_q, period_q, mask_q;
  logic                tick;

  assign tick = (pre_q == PW'(CLK_PER_TICK - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      period_q <= '0;
      mask_q   <= '0;
    end else if (!en_i) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      period_q <= start_period_i;
      mask_q   <= start_period_i >> 2;
    end else if (accept_i) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      period_q <= cnt_q;
      mask_q   <= cnt_q >> 2;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (mask_q != '0)     mask_q <= mask_q - 1'b1;
      end
    end
  end

  assign mask_active_o = (mask_q != '0);
  assign stall_o       = (cnt_q == CNT_MAX);

  assert_mask_quarter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q <= (period_q >> 2));

  assert_stall_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && en_i && !accept_i) |=> stall_o);

endmodule

// File: rtl/bemf_step_seq.sv
module bemf_step_seq
  import bemf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       stall_i,
  input  logic       accept_i,
  output logic [2:0] hs_en_o,
  output logic [2:0] ls_en_o,
  output logic [1:0] sense_sel_o,
  output logic       pol_o
);

  logic [STEP_W-1:0] step_q;
  drive_t            drv;
  logic              drive_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_q <= '0;
    else if (!en_i)     step_q <= '0;
    else if (accept_i)  step_q <= (step_q == STEP_W'(NUM_STEPS - 1)) ? '0 : step_q + 1'b1;
  end

  assign drv         = step_drive(step_q);
  assign drive_on    = en_i && !stall_i;
  assign hs_en_o     = drive_on ? drv.hs : 3'b000;
  assign ls_en_o     = drive_on ? drv.ls : 3'b000;
  assign sense_sel_o = drv.sense;
  assign pol_o       = drv.pol;

  assert_no_shoot_through_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o & ls_en_o) == 3'b000);

  assert_single_side_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hs_en_o) && $onehot0(ls_en_o));

  assert_step_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !accept_i) |=> $stable(step_q));

  assert_step_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < STEP_W'(NUM_STEPS));

  assert_off_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

  assert_off_when_stalled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

endmodule

// File: rtl/bemf_commutator.sv
module bemf_commutator #(
  parameter int unsigned PERIOD_W     = 16,
  parameter int unsigned CLK_PER_TICK = 125,
  parameter int unsigned FILT_LEN     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                cmp_i,
  input  logic [PERIOD_W-1:0] start_period_i,
  output logic [2:0]          hs_en_o,
  output logic [2:0]          ls_en_o,
  output logic [1:0]          sense_sel_o,
  output logic                stall_o
);

  logic level, mask_active, stall, pol, accept;

  bemf_sync_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_i),
    .level_o(level)
  );

  // crossing = filtered level reaches the polarity the current step expects
  assign accept = en_i && !mask_active && (level == pol);

  bemf_period_timer #(.PERIOD_W(PERIOD_W), .CLK_PER_TICK(CLK_PER_TICK)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .accept_i      (accept),
    .start_period_i(start_period_i),
    .mask_active_o (mask_active),
    .stall_o       (stall)
  );

  bemf_step_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .stall_i    (stall),
    .accept_i   (accept),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o),
    .sense_sel_o(sense_sel_o),
    .pol_o      (pol)
  );

  assign stall_o = stall;

  assert_no_accept_in_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_active |=> $stable(sense_sel_o) || !en_i);

endmodule

// File: tb/bemf_commutator_test.sv
module bemf_commutator_test;

  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0;
  logic          cmp = 1'b0;
  logic [PW-1:0] start_period = 12'd40;
  logic [2:0]    hs, ls;
  logic [1:0]    sense;
  logic          stall;

  int checks = 0;
  int fails  = 0;
  int cur_step = 0;

  always #4 clk = ~clk;

  bemf_commutator #(.PERIOD_W(PW), .CLK_PER_TICK(4), .FILT_LEN(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cmp_i(cmp),
    .start_period_i(start_period), .hs_en_o(hs), .ls_en_o(ls),
    .sense_sel_o(sense), .stall_o(stall)
  );

  function automatic int exp_hs(int s);
    case (s) 0, 1: return 1; 2, 3: return 2; default: return 4; endcase
  endfunction
  function automatic int exp_ls(int s);
    case (s) 0, 5: return 2; 1, 2: return 4; default: return 1; endcase
  endfunction
  function automatic int exp_sense(int s);
    case (s) 0, 3: return 2; 1, 4: return 1; default: return 0; endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_step(input int s, input string req);
    int act = {hs, ls, sense};
    int exp = (exp_hs(s) << 5) | (exp_ls(s) << 2) | exp_sense(s);
    check(act == exp, req, $sformatf("step %0d {hs,ls,sel}", s), act, exp);
  endtask

  task automatic wait_change(input int limit);
    logic [5:0] ref_v = {hs, ls};
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ({hs, ls} != ref_v) return;
    end
  endtask

  task automatic t_reset;
    check(hs == 3'b000 && ls == 3'b000, "R8", "enables in reset idle", {hs, ls}, 0);
    check(stall == 1'b0, "R7", "stall after reset", stall, 0);
  endtask

  task automatic t_enable;
    en = 1'b1;
    wait_cyc(5);
    cur_step = 0;
    expect_step(0, "R1");
  endtask

  task automatic t_rotate;
    for (int i = 0; i < 6; i++) begin
      wait_cyc(200);
      cmp = ~cmp;
      wait_cyc(20);
      cur_step = (cur_step + 1) % 6;
      expect_step(cur_step, i == 5 ? "R2" : "R1");
      check((hs & ls) == 3'b000, "R3", "hs&ls overlap", hs & ls, 0);
    end
  endtask

  task automatic t_glitch;
    wait_cyc(20);
    cmp = ~cmp; wait_cyc(1); cmp = ~cmp;
    wait_cyc(30);
    expect_step(cur_step, "R4");
    cmp = ~cmp; wait_cyc(2); cmp = ~cmp;
    wait_cyc(30);
    expect_step(cur_step, "R4");
    cmp = ~cmp;
    wait_cyc(20);
    cur_step = (cur_step + 1) % 6;
    expect_step(cur_step, "R4");
  endtask

  task automatic t_mask(input int gap, input int early, input int late);
    wait_cyc(gap);
    cmp = ~cmp;
    wait_change(100);
    cur_step = (cur_step + 1) % 6;
    expect_step(cur_step, "R2");
    wait_cyc(8);
    cmp = ~cmp;
    wait_cyc(early - 8);
    expect_step(cur_step, "R5");
    wait_cyc(late - early);
    cur_step = (cur_step + 1) % 6;
    expect_step(cur_step, "R6");
  endtask

  task automatic t_stall;
    wait_cyc(17000);
    check(stall == 1'b1, "R7", "stall after long gap", stall, 1);
    check(hs == 3'b000 && ls == 3'b000, "R7", "enables while stalled", {hs, ls}, 0);
    wait_cyc(500);
    check(stall == 1'b1, "R7", "counter saturates", stall, 1);
    cmp = ~cmp;
    wait_cyc(20);
    check(stall == 1'b0, "R7", "stall cleared by crossing", stall, 0);
    cur_step = (cur_step + 1) % 6;
    expect_step(cur_step, "R7");
  endtask

  task automatic t_reenable;
    en = 1'b0;
    start_period = 12'd100;
    wait_cyc(3);
    check(hs == 3'b000 && ls == 3'b000, "R8", "enables while disabled", {hs, ls}, 0);
    cmp = 1'b1;
    wait_cyc(10);
    en = 1'b1;
    wait_cyc(5);
    cur_step = 0;
    expect_step(0, "R8");
    wait_cyc(55);
    expect_step(0, "R8");
    wait_cyc(80);
    cur_step = 1;
    expect_step(1, "R8");
  endtask

  initial begin
    wait_cyc(5);
    rst_ni = 1'b1;
    wait_cyc(3);
    t_reset();
    t_enable();
    t_rotate();
    t_glitch();
    t_mask(200, 36, 100);
    t_mask(800, 150, 280);
    t_stall();
    t_reenable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule